// File: doc/BRIEF.md
# Micro-op Issue Bandwidth Allocator

This block sits at the issue point of an in-order pipeline. Each clock cycle stands for one issue cycle with a fixed budget of `ISSUE_W` micro-op slots. Up to `LANES` instructions are offered in program order, lane 0 being the oldest. In that same cycle the block decides which of them are accepted. Acceptance is always a prefix of the offered lanes: once one lane is refused, every younger lane is refused as well.

An instruction may need more micro-ops than one cycle can provide. Such an instruction is still accepted, and the micro-ops that did not fit are held as a pending leftover. That leftover uses up the slots of the following cycles before any new instruction can go. Instructions may also carry two markers. A group-start marker means the instruction must be the first to take slots in its cycle. A group-end marker means that no further slots are handed out in the cycle where the instruction finishes.

The hazard logic drives a stall input, which blocks all new acceptance. The registered outputs report the slots left at the end of the previous cycle and the state of the pending leftover.

Top module: `issue_bw_alloc`

## Requirements
- R1: During and just after a synchronous active-high reset, `bw_left_o` equals `ISSUE_W`, `carry_busy_o` is 0 and `carry_left_o` is 0.
- R2: Every cycle starts with `ISSUE_W` fresh slots. Lane i (bit i of the lane vectors and of `accept_o`) can be accepted only if it is valid and lanes 0..i-1 are all accepted, so `accept_o` is always a prefix of ones from bit 0. `bw_left_o` shows the slots that remained when the previous cycle ended.
- R3: An instruction needing at most `ISSUE_W` micro-ops is accepted only when the slots still remaining are at least its micro-op count, and each such instruction uses up its count.
- R4: An instruction needing more than `ISSUE_W` micro-ops is accepted whatever the remaining slots are, even zero. The leftover (micro-ops minus remaining slots) is stored and `carry_busy_o` rises. The remaining slots become 0, and no younger lane is accepted in that cycle.
- R5: A group-start instruction is accepted only when no micro-ops of instructions accepted in the current cycle have taken slots yet. Slots consumed by finishing a leftover do not count.
- R6: An accepted instruction that fits and carries the group-end marker sets the remaining slots to 0 for the rest of the cycle.
- R7: At the start of a cycle, a pending leftover larger than `ISSUE_W` is reduced by `ISSUE_W`. That cycle has 0 remaining slots and accepts nothing.
- R8: A pending leftover of at most `ISSUE_W` completes at the start of the cycle and `carry_busy_o` falls. The remaining slots become `ISSUE_W` minus the leftover, or 0 if the carried instruction had the group-end marker. New instructions may be accepted in that same cycle.
- R9: While `stall_i` is high, nothing is accepted and the cycle ends with 0 remaining slots. A pending leftover still drains as in R7 and R8.
- R10: The micro-ops of accepted instructions that fit within `ISSUE_W` never add up to more than `ISSUE_W` in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hazard stall; blocks new acceptance |
| lane_valid_i | input | LANES | Lane holds an instruction |
| lane_uops_i | input | LANES*UOP_W | Micro-op count per lane, lane i at bits [i*UOP_W +: UOP_W] |
| lane_begin_i | input | LANES | Group-start marker per lane |
| lane_end_i | input | LANES | Group-end marker per lane |
| accept_o | output | LANES | Lane accepted this cycle (combinational) |
| bw_left_o | output | $clog2(ISSUE_W+1) | Slots left at the end of the previous cycle |
| carry_busy_o | output | 1 | A leftover is pending for the coming cycle |
| carry_left_o | output | UOP_W | Pending leftover micro-op count |

## Verification
The bench builds the block with its defaults: `ISSUE_W` = 4, `LANES` = 3 and `UOP_W` = 4. With three lanes, one cycle can show a refusal in the middle of the lane order, a group-start instruction behind an older one, and a wide instruction that is accepted with zero slots left. A 4-bit count allows instructions of up to 15 micro-ops. That makes leftovers that need two or more draining cycles, leftovers that equal the issue width exactly, and leftovers that complete under a stall.

// File: rtl/issue_bw_pkg.sv
package issue_bw_pkg;

  // Outcome of the leftover handling at the start of a cycle.
  typedef enum logic [1:0] {
    CARRY_NONE   = 2'd0,
    CARRY_DRAIN  = 2'd1,
    CARRY_FINISH = 2'd2
  } carry_phase_e;

  // Registered leftover state.
  typedef struct packed {
    logic       pend;
    logic       grp_end;
    logic [7:0] left;
  } carry_state_t;

endpackage

// File: rtl/issue_bw_carry.sv
module issue_bw_carry #(
  parameter int ISSUE_W = 4,
  parameter int UOP_W   = 4
) (
  input  logic             pend_i,
  input  logic             grp_end_i,
  input  logic [UOP_W-1:0] left_i,
  output logic             pend_o,
  output logic [UOP_W-1:0] left_o,
  output logic [UOP_W-1:0] bw_start_o,
  output issue_bw_pkg::carry_phase_e phase_o
);
  import issue_bw_pkg::*;

  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(ISSUE_W);

  always_comb begin
    phase_o    = CARRY_NONE;
    pend_o     = 1'b0;
    left_o     = '0;
    bw_start_o = WIDTH_U;
    if (pend_i) begin
      if (left_i > WIDTH_U) begin
        phase_o    = CARRY_DRAIN;
        pend_o     = 1'b1;
        left_o     = left_i - WIDTH_U;
        bw_start_o = '0;
      end else begin
        phase_o    = CARRY_FINISH;
        bw_start_o = grp_end_i ? '0 : (WIDTH_U - left_i);
      end
    end
  end

endmodule

// File: rtl/issue_bw_lane.sv
module issue_bw_lane #(
  parameter int ISSUE_W = 4,
  parameter int UOP_W   = 4
) (
  input  logic             open_i,
  input  logic             valid_i,
  input  logic             begin_i,
  input  logic             end_i,
  input  logic [UOP_W-1:0] uops_i,
  input  logic [UOP_W-1:0] bw_i,
  input  logic [UOP_W-1:0] issued_i,
  output logic             acc_o,
  output logic             open_o,
  output logic             carry_o,
  output logic [UOP_W-1:0] carry_amt_o,
  output logic [UOP_W-1:0] bw_o,
  output logic [UOP_W-1:0] issued_o
);

  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(ISSUE_W);

  logic wide, fits, group_ok;

  always_comb begin
    wide        = uops_i > WIDTH_U;
    fits        = uops_i <= bw_i;
    group_ok    = !begin_i || (issued_i == '0);
    acc_o       = open_i && valid_i && group_ok && (wide || fits);
    carry_o     = acc_o && wide;
    carry_amt_o = uops_i - bw_i;
    open_o      = acc_o && !wide;
    bw_o        = bw_i;
    issued_o    = issued_i;
    if (carry_o) begin
      bw_o = '0;
    end else if (acc_o) begin
      bw_o     = end_i ? '0 : (bw_i - uops_i);
      issued_o = issued_i + uops_i;
    end
  end

endmodule

// File: rtl/issue_bw_alloc.sv
module issue_bw_alloc #(
  parameter int ISSUE_W = 4,
  parameter int LANES   = 3,
  parameter int UOP_W   = 4,
  localparam int BW_W   = $clog2(ISSUE_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stall_i,
  input  logic [LANES-1:0]       lane_valid_i,
  input  logic [LANES*UOP_W-1:0] lane_uops_i,
  input  logic [LANES-1:0]       lane_begin_i,
  input  logic [LANES-1:0]       lane_end_i,
  output logic [LANES-1:0]       accept_o,
  output logic [BW_W-1:0]        bw_left_o,
  output logic                   carry_busy_o,
  output logic [UOP_W-1:0]       carry_left_o
);
  import issue_bw_pkg::*;

  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(ISSUE_W);

  logic             pend_q, grp_end_q;
  logic [UOP_W-1:0] left_q, bw_q;

  logic             pend_s;
  logic [UOP_W-1:0] left_s, bw_start;
  carry_phase_e     phase;

  logic [LANES:0]   open_c;
  logic [UOP_W-1:0] bw_c  [LANES+1];
  logic [UOP_W-1:0] iss_c [LANES+1];
  logic [LANES-1:0] carry_v;
  logic [UOP_W-1:0] carry_amt [LANES];

  logic             pend_d, grp_end_d;
  logic [UOP_W-1:0] left_d, bw_d;

  issue_bw_carry #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W)) u_carry (
    .pend_i     (pend_q),
    .grp_end_i  (grp_end_q),
    .left_i     (left_q),
    .pend_o     (pend_s),
    .left_o     (left_s),
    .bw_start_o (bw_start),
    .phase_o    (phase)
  );

  assign open_c[0] = !stall_i && !pend_s;
  assign bw_c[0]   = bw_start;
  assign iss_c[0]  = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    issue_bw_lane #(.ISSUE_W(ISSUE_W), .UOP_W(UOP_W)) u_lane (
      .open_i      (open_c[i]),
      .valid_i     (lane_valid_i[i]),
      .begin_i     (lane_begin_i[i]),
      .end_i       (lane_end_i[i]),
      .uops_i      (lane_uops_i[i*UOP_W +: UOP_W]),
      .bw_i        (bw_c[i]),
      .issued_i    (iss_c[i]),
      .acc_o       (accept_o[i]),
      .open_o      (open_c[i+1]),
      .carry_o     (carry_v[i]),
      .carry_amt_o (carry_amt[i]),
      .bw_o        (bw_c[i+1]),
      .issued_o    (iss_c[i+1])
    );
  end

  // Next leftover state: a new wide acceptance overrides the drained one.
  always_comb begin
    pend_d    = pend_s;
    left_d    = left_s;
    grp_end_d = (phase == CARRY_DRAIN) ? grp_end_q : 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (carry_v[i]) begin
        pend_d    = 1'b1;
        left_d    = carry_amt[i];
        grp_end_d = lane_end_i[i];
      end
    end
    bw_d = stall_i ? '0 : bw_c[LANES];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      grp_end_q <= 1'b0;
      left_q    <= '0;
      bw_q      <= WIDTH_U;
    end else begin
      pend_q    <= pend_d;
      grp_end_q <= grp_end_d;
      left_q    <= left_d;
      bw_q      <= bw_d;
    end
  end

  assign bw_left_o    = bw_q[BW_W-1:0];
  assign carry_busy_o = pend_q;
  assign carry_left_o = left_q;

endmodule

// File: rtl/issue_bw_alloc_chk.sv
module issue_bw_alloc_chk #(
  parameter int ISSUE_W = 4,
  parameter int LANES   = 3,
  parameter int UOP_W   = 4,
  localparam int BW_W   = $clog2(ISSUE_W + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   stall_i,
  input logic [LANES*UOP_W-1:0] lane_uops_i,
  input logic [LANES-1:0]       accept_o,
  input logic [BW_W-1:0]        bw_left_o,
  input logic                   carry_busy_o,
  input logic [UOP_W-1:0]       carry_left_o
);

  logic [UOP_W+7:0] fit_sum;
  logic             wide_acc;

  always_comb begin
    fit_sum  = '0;
    wide_acc = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (accept_o[i]) begin
        if (lane_uops_i[i*UOP_W +: UOP_W] > UOP_W'(ISSUE_W)) wide_acc = 1'b1;
        else fit_sum = fit_sum + (UOP_W+8)'(lane_uops_i[i*UOP_W +: UOP_W]);
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bw_left_o == BW_W'(ISSUE_W) && !carry_busy_o && carry_left_o == '0)); // R1
  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((accept_o & (accept_o + 1'b1)) == '0)); // R2
  AST_WIDE_PENDS: assert property (@(posedge clk) disable iff (rst)
    wide_acc |=> carry_busy_o); // R4
  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (carry_busy_o && carry_left_o > UOP_W'(ISSUE_W)) |-> (accept_o == '0)); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> (accept_o == '0)); // R9
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> (bw_left_o == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fit_sum <= (UOP_W+8)'(ISSUE_W)); // R10

endmodule

bind issue_bw_alloc issue_bw_alloc_chk #(
  .ISSUE_W(ISSUE_W), .LANES(LANES), .UOP_W(UOP_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall_i      (stall_i),
  .lane_uops_i  (lane_uops_i),
  .accept_o     (accept_o),
  .bw_left_o    (bw_left_o),
  .carry_busy_o (carry_busy_o),
  .carry_left_o (carry_left_o)
);

// File: tb/issue_bw_alloc_tb_top.sv
module issue_bw_alloc_tb_top;

  localparam int ISSUE_W = 4;
  localparam int LANES   = 3;
  localparam int UOP_W   = 4;
  localparam int BW_W    = $clog2(ISSUE_W + 1);

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   stall_i = 1'b0;
  logic [LANES-1:0]       lane_valid_i = '0;
  logic [LANES*UOP_W-1:0] lane_uops_i = '0;
  logic [LANES-1:0]       lane_begin_i = '0;
  logic [LANES-1:0]       lane_end_i = '0;
  logic [LANES-1:0]       accept_o;
  logic [BW_W-1:0]        bw_left_o;
  logic                   carry_busy_o;
  logic [UOP_W-1:0]       carry_left_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  issue_bw_alloc #(.ISSUE_W(ISSUE_W), .LANES(LANES), .UOP_W(UOP_W)) dut_i (
    .clk (clk), .rst (rst), .stall_i (stall_i),
    .lane_valid_i (lane_valid_i), .lane_uops_i (lane_uops_i),
    .lane_begin_i (lane_begin_i), .lane_end_i (lane_end_i),
    .accept_o (accept_o), .bw_left_o (bw_left_o),
    .carry_busy_o (carry_busy_o), .carry_left_o (carry_left_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One issue cycle: drive at negedge, check accept before the edge,
  // check registered outputs just after it.
  task automatic step(input string tag, input logic [2:0] v,
                      input int u0, input int u1, input int u2,
                      input logic [2:0] bg, input logic [2:0] en,
                      input logic st, input int exp_acc, input int exp_bw,
                      input int exp_busy, input int exp_left);
    lane_valid_i = v;
    lane_uops_i  = {UOP_W'(u2), UOP_W'(u1), UOP_W'(u0)};
    lane_begin_i = bg;
    lane_end_i   = en;
    stall_i      = st;
    #2;
    chk({tag, " accept"}, int'(accept_o), exp_acc);
    @(posedge clk); #1;
    chk({tag, " bw_left"}, int'(bw_left_o), exp_bw);
    chk({tag, " carry_busy"}, int'(carry_busy_o), exp_busy);
    chk({tag, " carry_left"}, int'(carry_left_o), exp_left);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset bw", int'(bw_left_o), ISSUE_W);
    chk("R1 reset busy", int'(carry_busy_o), 0);
    rst = 1'b0;
    step("R1 idle after reset", 3'b000, 0, 0, 0, 3'b000, 3'b000, 1'b0, 0, 4, 0, 0);
  endtask

  task automatic t_basic;
    step("R2 three fit", 3'b111, 1, 2, 1, 3'b000, 3'b000, 1'b0, 7, 0, 0, 0);
    step("R2 lane0 invalid", 3'b110, 1, 1, 1, 3'b000, 3'b000, 1'b0, 0, 4, 0, 0);
  endtask

  task automatic t_limit;
    step("R3 third overflows", 3'b111, 2, 2, 1, 3'b000, 3'b000, 1'b0, 3, 0, 0, 0);
    step("R3 in-order refusal", 3'b111, 3, 2, 1, 3'b000, 3'b000, 1'b0, 1, 1, 0, 0);
  endtask

  task automatic t_groups;
    step("R5 begin behind older", 3'b011, 1, 1, 0, 3'b010, 3'b000, 1'b0, 1, 3, 0, 0);
    step("R5 begin first", 3'b011, 2, 1, 0, 3'b001, 3'b000, 1'b0, 3, 1, 0, 0);
    step("R6 end closes cycle", 3'b011, 1, 1, 0, 3'b000, 3'b001, 1'b0, 1, 0, 0, 0);
  endtask

  task automatic t_wide;
    step("R4 wide accepted", 3'b111, 10, 1, 1, 3'b000, 3'b000, 1'b0, 1, 0, 1, 6);
    step("R7 drain blocks", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b0, 0, 0, 1, 2);
    step("R8 finish then issue", 3'b111, 1, 1, 1, 3'b000, 3'b000, 1'b0, 3, 0, 0, 0);
    step("R4 wide after fit", 3'b111, 1, 7, 1, 3'b000, 3'b000, 1'b0, 3, 0, 1, 4);
    step("R8 exact finish", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b0, 0, 0, 0, 0);
    step("R2 fresh slots", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b0, 1, 3, 0, 0);
    step("R4 wide at zero", 3'b011, 4, 5, 0, 3'b000, 3'b000, 1'b0, 3, 0, 1, 5);
    step("R7 drain again", 3'b000, 0, 0, 0, 3'b000, 3'b000, 1'b0, 0, 0, 1, 1);
    step("R8 finish leaves 3", 3'b000, 0, 0, 0, 3'b000, 3'b000, 1'b0, 0, 3, 0, 0);
    step("R4 wide end-group", 3'b001, 6, 0, 0, 3'b000, 3'b001, 1'b0, 1, 0, 1, 2);
    step("R8 end-group finish", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_stall;
    step("R9 stall blocks", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b1, 0, 0, 0, 0);
    step("R4 wide nine", 3'b001, 9, 0, 0, 3'b000, 3'b000, 1'b0, 1, 0, 1, 5);
    step("R9 drain under stall", 3'b001, 1, 0, 0, 3'b000, 3'b000, 1'b1, 0, 0, 1, 1);
    step("R5 begin after finish", 3'b001, 3, 0, 0, 3'b001, 3'b000, 1'b0, 1, 0, 0, 0);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_limit();
    t_groups();
    t_wide();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule